// File: doc/BRIEF.md
# Parallel Streaming Bit-Reversal Permuter

This block takes a gap-free stream of frames of 2^LOG_N words and hands each frame back in bit-reversed index order. Words travel 2^LOG_P per clock on both sides. It is meant to sit between the stages of a multi-lane pipelined FFT. There, one stage emits results in natural order and the next stage needs them in bit-reversed order.

Storage is one single-port bank per lane, each 2^(LOG_N-LOG_P) entries deep, so the whole block holds exactly 2^LOG_N words. Each enabled cycle, every bank is visited at one address. The old word is read out and the incoming word is stored in the same place. The order in which the banks are addressed switches between two patterns on alternate frames, so a frame can always be written into the slots its predecessor is vacating. Lanes are steered into and out of the banks by barrel rotators built from ranks of 2-to-1 multiplexers, plus fixed lane-reversal wiring. Control is a frame-position counter, a frame-parity bit and two start-up flags. The build requires LOG_N > 2*LOG_P.

Top module: `bitrev_stream`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, out_valid and out_sof are 0.
- R2: Input cycle c of a frame carries word index c*P+l on lane l, where P=2^LOG_P and lane l is in_data[l*WIDTH +: WIDTH]. Output cycle c of the frame carries, on lane l, the input word whose index is the LOG_N-bit reversal of c*P+l.
- R3: When the input is continuous, the first output word of a frame appears exactly F+1 cycles after that frame's first input cycle, where F=2^(LOG_N-LOG_P).
- R4: When frames arrive back to back, the output is also back to back. Once output has started, out_valid stays 1 in every cycle that follows an accepted input cycle.
- R5: A cycle with in_valid=0 freezes the block. out_valid is 0 in the next cycle, and the word order of every frame is unaffected by such gaps.
- R6: Valid input words seen before the first in_sof after reset are discarded. Word counting starts at the word that carries in_sof.
- R7: out_sof is 1 only together with out_valid, and only on the first output cycle of each frame, that is, once every F valid output cycles.
- R8: A frame is emitted while the next frame is being accepted. With only one frame supplied, no output appears, however long the input stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input lanes carry words this cycle |
| in_sof | input | 1 | First cycle of an input frame (the first one after reset starts the stream) |
| in_data | input | P*WIDTH | Input lanes, lane l at bits l*WIDTH +: WIDTH |
| out_valid | output | 1 | Output lanes carry words this cycle |
| out_sof | output | 1 | First cycle of an output frame |
| out_data | output | P*WIDTH | Output lanes, same packing as in_data |

## Verification
The two operations that share a cycle are draining frame f and filling frame f+1. In each bank, the location read for an output word is overwritten by an incoming word on the same clock. Back-to-back frames with distinct tags trigger this case in every bank on every cycle. Every output word is compared with a reference built from the frame tag and the reversed index, so any slot that is overwritten too early or read from the wrong bank shows up as a mismatched word. Streams broken by idle cycles check the same overlap after stalls.

// File: rtl/bitrev_pkg.sv
// Package for the bit-reversal permuter.
// Holds the bank-addressing mode and a constant index-reversal helper
// that is used only when wiring is built at elaboration.
package bitrev_pkg;

    // Addressing pattern used for the frame currently being written
    typedef enum logic {
        MAP_NAT = 1'b0,
        MAP_REV = 1'b1
    } map_mode_e;

    // Reverse the low w bits of v (used for elaboration-time wiring only)
    function automatic int rev_idx(input int v, input int w);
        int r;
        r = 0;
        for (int i = 0; i < w; i++) begin
            r = (r << 1) | ((v >> i) & 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/bitrev_ctrl.sv
// Frame controller.
// Counts input cycles within a frame, flips the addressing mode at every
// frame boundary and produces the output flags. It assumes in_valid marks
// every accepted cycle. The first in_sof after reset starts counting, and
// later in_sof values are not looked at.
module bitrev_ctrl
    import bitrev_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic            in_sof,
    output logic            step,
    output logic [AW-1:0]   cnt,
    output map_mode_e       mode,
    output logic            out_valid,
    output logic            out_sof
);

    logic run;
    logic par;
    logic primed;

    // Accept a cycle once the stream has started, or on the word that starts it
    assign step = in_valid && (run || in_sof);
    assign mode = par ? MAP_REV : MAP_NAT;

    // Position counter, frame parity, start-up flags and output flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run       <= 1'b0;
            cnt       <= '0;
            par       <= 1'b0;
            primed    <= 1'b0;
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
        end else begin
            out_valid <= step && primed;
            out_sof   <= step && primed && (cnt == '0);
            if (step) begin
                run <= 1'b1;
                cnt <= cnt + AW'(1);
                if (&cnt) begin
                    par    <= ~par;
                    primed <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/bitrev_map.sv
// Bank address and lane-rotation generator.
// Given the position counter and the addressing mode, it returns one address
// per bank and the rotation amount that maps lanes onto banks. Natural mode:
// every bank uses the counter as its address, and the rotation is the top
// LOG_P counter bits. Reversed mode: the counter is bit-reversed; its low
// LOG_P bits give the rotation, and each bank's address is its offset from
// that rotation joined to the remaining reversed bits. Assumes AW > LOG_P.
module bitrev_map
    import bitrev_pkg::*;
#(
    parameter int LOG_P = 2,
    parameter int AW    = 4
) (
    input  logic [AW-1:0]          cnt,
    input  map_mode_e              mode,
    output logic [LOG_P-1:0]       shift,
    output logic [(1<<LOG_P)*AW-1:0] addr
);

    localparam int P  = 1 << LOG_P;
    localparam int TW = AW - LOG_P;

    logic [AW-1:0]    rc;
    logic [LOG_P-1:0] rx;
    logic [TW-1:0]    rtop;

    // Reversed counter, by wiring
    for (genvar j = 0; j < AW; j++) begin : g_rev
        assign rc[j] = cnt[AW-1-j];
    end

    assign rx    = rc[LOG_P-1:0];
    assign rtop  = rc[AW-1:LOG_P];
    assign shift = (mode == MAP_REV) ? rx : cnt[AW-1 -: LOG_P];

    // One address per bank
    for (genvar b = 0; b < P; b++) begin : g_addr
        logic [LOG_P-1:0] off;
        assign off = LOG_P'(b) - rx;
        assign addr[b*AW +: AW] = (mode == MAP_REV) ? {off, rtop} : cnt;
    end

endmodule

// File: rtl/bitrev_rot.sv
// Lane barrel rotator made of LOG_P ranks of 2-to-1 multiplexers.
// SUB=1: out[b] = in[(b - amt) mod P]; SUB=0: out[b] = in[(b + amt) mod P].
module bitrev_rot #(
    parameter int LOG_P = 2,
    parameter int W     = 16,
    parameter bit SUB   = 1'b1
) (
    input  logic [(1<<LOG_P)*W-1:0] din,
    input  logic [LOG_P-1:0]        amt,
    output logic [(1<<LOG_P)*W-1:0] dout
);

    localparam int P = 1 << LOG_P;

    logic [W-1:0] st [LOG_P+1][P];

    // Unpack the lanes into rank 0
    for (genvar l = 0; l < P; l++) begin : g_in
        assign st[0][l] = din[l*W +: W];
        assign dout[l*W +: W] = st[LOG_P][l];
    end

    // Rank s rotates by 2^s when amt[s] is set
    for (genvar s = 0; s < LOG_P; s++) begin : g_rank
        for (genvar l = 0; l < P; l++) begin : g_lane
            localparam int SRC = SUB ? ((l - (1 << s) + P) % P) : ((l + (1 << s)) % P);
            assign st[s+1][l] = amt[s] ? st[s][SRC] : st[s][l];
        end
    end

endmodule

// File: rtl/bitrev_bank.sv
// Single-port bank with read-before-write.
// With en set, the word at addr is returned on rq after the clock, and wd
// replaces it on the same edge. One address per cycle; not reset.
module bitrev_bank #(
    parameter int AW = 4,
    parameter int W  = 16
) (
    input  logic          clk,
    input  logic          en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wd,
    output logic [W-1:0]  rq
);

    logic [W-1:0] mem [1<<AW];

    // Read the old word and store the new one at the same address
    always_ff @(posedge clk) begin
        if (en) begin
            rq        <= mem[addr];
            mem[addr] <= wd;
        end
    end

endmodule

// File: rtl/bitrev_stream.sv
// Parallel streaming bit-reversal permuter, top level.
// Writes each frame into P single-port banks while the previous frame is
// read from the very same slots, so the total storage is one frame. Write
// steering: optional lane-reversal wiring, then a rotator. Read steering: the
// mirror of that, driven by the mapping registered one cycle earlier to
// match the bank read delay. Assumes LOG_N > 2*LOG_P.
module bitrev_stream
    import bitrev_pkg::*;
#(
    parameter int LOG_N = 6,
    parameter int LOG_P = 2,
    parameter int WIDTH = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic                        in_sof,
    input  logic [(1<<LOG_P)*WIDTH-1:0] in_data,
    output logic                        out_valid,
    output logic                        out_sof,
    output logic [(1<<LOG_P)*WIDTH-1:0] out_data
);

    localparam int P  = 1 << LOG_P;
    localparam int AW = LOG_N - LOG_P;
    localparam int F  = 1 << AW;
    localparam int DW = P * WIDTH;

    logic            step;
    logic [AW-1:0]   cnt;
    map_mode_e       mode;
    map_mode_e       rd_mode_q;
    logic [LOG_P-1:0] shift;
    logic [LOG_P-1:0] rd_shift_q;
    logic [P*AW-1:0] addr;
    logic [DW-1:0]   in_rev;
    logic [DW-1:0]   wr_pre;
    logic [DW-1:0]   bank_wd;
    logic [DW-1:0]   bank_q;
    logic [DW-1:0]   rd_rot;
    logic [DW-1:0]   rd_rev;

    bitrev_ctrl #(.AW(AW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .step     (step),
        .cnt      (cnt),
        .mode     (mode),
        .out_valid(out_valid),
        .out_sof  (out_sof)
    );

    bitrev_map #(.LOG_P(LOG_P), .AW(AW)) u_map (
        .cnt  (cnt),
        .mode (mode),
        .shift(shift),
        .addr (addr)
    );

    // Fixed lane-reversal wiring for both directions
    for (genvar l = 0; l < P; l++) begin : g_lrev
        localparam int RL = rev_idx(l, LOG_P);
        assign in_rev[l*WIDTH +: WIDTH] = in_data[RL*WIDTH +: WIDTH];
        assign rd_rev[l*WIDTH +: WIDTH] = rd_rot[RL*WIDTH +: WIDTH];
    end

    assign wr_pre = (mode == MAP_REV) ? in_rev : in_data;

    bitrev_rot #(.LOG_P(LOG_P), .W(WIDTH), .SUB(1'b1)) u_wrot (
        .din (wr_pre),
        .amt (shift),
        .dout(bank_wd)
    );

    for (genvar b = 0; b < P; b++) begin : g_bank
        bitrev_bank #(.AW(AW), .W(WIDTH)) u_bank (
            .clk (clk),
            .en  (step),
            .addr(addr[b*AW +: AW]),
            .wd  (bank_wd[b*WIDTH +: WIDTH]),
            .rq  (bank_q[b*WIDTH +: WIDTH])
        );
    end

    // Keep the mapping of the cycle whose read data is now on bank_q
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_mode_q  <= MAP_NAT;
            rd_shift_q <= '0;
        end else if (step) begin
            rd_mode_q  <= mode;
            rd_shift_q <= shift;
        end
    end

    bitrev_rot #(.LOG_P(LOG_P), .W(WIDTH), .SUB(1'b0)) u_rrot (
        .din (bank_q),
        .amt (rd_shift_q),
        .dout(rd_rot)
    );

    assign out_data = (rd_mode_q == MAP_REV) ? rd_rev : rd_rot;

endmodule

// File: rtl/bitrev_checks.sv
// Port-level properties of the permuter, bound into every instance.
// Tracks the number of valid output cycles in a frame with its own counter.
module bitrev_checks #(
    parameter int FRAME_LEN = 16
) (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic out_valid,
    input logic out_sof
);

    int vcnt;

    // Count valid output cycles modulo the frame length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vcnt <= 0;
        end else if (out_valid) begin
            vcnt <= (vcnt == FRAME_LEN - 1) ? 0 : vcnt + 1;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && !out_sof));

    assert_back_to_back_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(out_valid) && $past(in_valid)) |-> out_valid);

    assert_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_sof_in_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_valid);

    assert_sof_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_sof == (vcnt == 0)));

endmodule

bind bitrev_stream bitrev_checks #(.FRAME_LEN(F)) u_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .out_valid(out_valid),
    .out_sof  (out_sof)
);

// File: tb/bitrev_stream_bench.sv
// Directed bench: each scenario task drives a stream and checks its counts.
// A negedge monitor compares every output word with a reference built from
// the frame tag and the bit-reversed index.
module bitrev_stream_bench;

    localparam int LOG_N = 6;
    localparam int LOG_P = 2;
    localparam int WIDTH = 16;
    localparam int P     = 1 << LOG_P;
    localparam int F     = 1 << (LOG_N - LOG_P);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_sof = 1'b0;
    logic [P*WIDTH-1:0] in_data = '0;
    logic out_valid;
    logic out_sof;
    logic [P*WIDTH-1:0] out_data;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int nout = 0;
    int t_in = 0;
    int t_out = 0;
    int first_out = 0;
    int last_out = 0;
    bit got_in = 0;
    bit got_out = 0;
    bit prev_in_valid = 0;
    int pos = 0;
    logic [7:0] cur_tag = '0;
    logic [7:0] tagq[$];

    bitrev_stream #(.LOG_N(LOG_N), .LOG_P(LOG_P), .WIDTH(WIDTH)) u_bitrev_stream (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_data(in_data), .out_valid(out_valid), .out_sof(out_sof), .out_data(out_data)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int rev_n(input int v);
        int r = 0;
        for (int i = 0; i < LOG_N; i++) r = (r << 1) | ((v >> i) & 1);
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: R2 word order, R5 stall, first-frame timing for R3
    always @(negedge clk) begin
        if (rst_n) begin
            if (!prev_in_valid)
                check(!out_valid, "R5 out_valid after idle input", int'(out_valid), 0);
            if (in_valid && in_sof && !got_in) begin
                t_in = cyc;
                got_in = 1;
            end
            if (out_valid) begin
                if (out_sof) begin
                    if (tagq.size() == 0) begin
                        check(0, "R2 frame with no matching input", 0, 1);
                    end else begin
                        cur_tag = tagq.pop_front();
                    end
                    pos = 0;
                    if (!got_out) begin
                        t_out = cyc;
                        first_out = cyc;
                        got_out = 1;
                    end
                end
                for (int l = 0; l < P; l++) begin
                    logic [15:0] exp_w;
                    exp_w = {cur_tag, 8'(rev_n(pos + l))};
                    check(out_data[l*WIDTH +: WIDTH] == exp_w, "R2 output word",
                          int'(out_data[l*WIDTH +: WIDTH]), int'(exp_w));
                end
                pos += P;
                nout++;
                last_out = cyc;
            end
        end
        prev_in_valid = in_valid;
    end

    task automatic drive(input bit v, input bit s, input logic [7:0] tag, input int c);
        @(posedge clk);
        #1;
        in_valid = v;
        in_sof = s;
        for (int l = 0; l < P; l++) in_data[l*WIDTH +: WIDTH] = {tag, 8'(c*P + l)};
    endtask

    task automatic send_frame(input logic [7:0] tag, input int gap_every);
        tagq.push_back(tag);
        for (int c = 0; c < F; c++) begin
            drive(1, c == 0, tag, c);
            if (gap_every > 0 && (c % gap_every) == gap_every - 1) drive(0, 0, 8'hFF, 0);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, 0, 8'h00, 0);
    endtask

    task automatic do_reset();
        @(posedge clk);
        #1;
        rst_n = 0;
        in_valid = 0;
        in_sof = 0;
        repeat (3) @(posedge clk);
        #1;
        tagq.delete();
        nout = 0;
        got_in = 0;
        got_out = 0;
        prev_in_valid = 0;
        rst_n = 1;
    endtask

    // R1: quiet outputs after reset
    task automatic t_reset();
        do_reset();
        @(negedge clk);
        check(!out_valid, "R1 out_valid after reset", int'(out_valid), 0);
        check(!out_sof, "R1 out_sof after reset", int'(out_sof), 0);
        idle(4);
        check(nout == 0, "R1 no output while idle", nout, 0);
    endtask

    // R2, R3, R4, R7: four frames back to back
    task automatic t_back_to_back();
        do_reset();
        for (int f = 0; f < 4; f++) send_frame(8'(8'h10 + f), 0);
        idle(F + 4);
        check(nout == 3 * F, "R4 output cycles for three frames", nout, 3 * F);
        check(t_out - t_in == F + 1, "R3 latency", t_out - t_in, F + 1);
        check(last_out - first_out + 1 == nout, "R4 output without gaps",
              last_out - first_out + 1, nout);
        check(tagq.size() == 1, "R7 one frame still held", tagq.size(), 1);
    endtask

    // R8 and R5: one frame, long idle, then more frames
    task automatic t_single_then_more();
        do_reset();
        send_frame(8'h30, 0);
        idle(3 * F);
        check(nout == 0, "R8 lone frame stays inside", nout, 0);
        send_frame(8'h31, 0);
        send_frame(8'h32, 0);
        idle(F + 4);
        check(nout == 2 * F, "R8 frames released by successors", nout, 2 * F);
    endtask

    // R5: gaps inside frames keep order
    task automatic t_gaps();
        do_reset();
        send_frame(8'h40, 3);
        send_frame(8'h41, 5);
        send_frame(8'h42, 2);
        idle(2 * F + 4);
        check(nout == 2 * F, "R5 output cycles with gaps", nout, 2 * F);
    endtask

    // R6: valid words before the first in_sof are dropped
    task automatic t_before_sof();
        do_reset();
        for (int i = 0; i < 5; i++) drive(1, 0, 8'hEE, i);
        send_frame(8'h50, 0);
        send_frame(8'h51, 0);
        send_frame(8'h52, 0);
        idle(F + 4);
        check(nout == 2 * F, "R6 output cycles after late start", nout, 2 * F);
        check(t_out - t_in == F + 1, "R6 counting starts at in_sof", t_out - t_in, F + 1);
    endtask

    initial begin
        t_reset();
        t_back_to_back();
        t_single_then_more();
        t_gaps();
        t_before_sof();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1ms;
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule